// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compare

This block is the arithmetic and logic unit of a small load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit shift amount and a 4-bit operation code, and it returns a 32-bit result and a flag that marks a zero result. It holds no state. The core's branch logic uses the flag to test two registers for equality by subtracting them.

Add, subtract and both set-less-than forms share one carry chain. The signed compare takes its answer from the sign of the difference and uses the sign bits directly when the operands have opposite signs. The unsigned compare takes its answer from the borrow. Logical inversion is done with NOR against a zero operand. The upper-immediate operation takes a 16-bit constant from the low half of the second operand and moves it into the high half of the result. Choosing operands, extending immediates and trapping on overflow are left to the rest of the core.

Top module: `risc_alu`

## Requirements
- R1: With op code 0 (add), the result is (A + B) mod 2^32. Overflow raises nothing.
- R2: With op code 1 (subtract), the result is A + ~B + 1 mod 2^32, which equals A - B with wrap-around.
- R3: With op code 2 the result is the bitwise A AND B. With op code 3 the result is the bitwise A OR B.
- R4: With op code 4 the result is ~(A | B). When B is zero, this is the bitwise inverse of A.
- R5: With op code 5 the result is A shifted left by the shift amount (0 to 31). Vacated low bits are 0 and B has no effect.
- R6: With op code 6 the result is A shifted right by the shift amount. Vacated high bits are 0 and B has no effect.
- R7: With op code 7 the result is 1 when A < B as two's-complement values and 0 otherwise. For example, 0xFFFFFFFF against 0x00000001 gives 1. Bits 31..1 are always 0.
- R8: With op code 8 the result is 1 when A < B as unsigned values and 0 otherwise. For example, 0xFFFFFFFF against 0x00000001 gives 0.
- R9: With op code 9 the result is B[15:0] in bits 31..16, and bits 15..0 are 0. A has no effect.
- R10: Op codes 10 to 15 give a result of 0.
- R11: The zero flag is 1 exactly when all 32 result bits are 0. In particular, subtracting equal operands sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand. Shifts move this operand. |
| opnd_b | input | 32 | Second operand. Its low half is the constant for the upper-immediate operation. |
| shift_amt | input | 5 | Shift distance for op codes 5 and 6 |
| op_sel | input | 4 | Operation code, encoded as listed in R1 to R10 |
| result | output | 32 | Result of the operation |
| zero | output | 1 | 1 when the result is all zeros |

## Verification
The block has no registers, so both the result and the zero flag are due as soon as the inputs settle, in the same cycle they are applied. The bench changes the inputs two time units after a rising clock edge. It samples the outputs three time units later, which is after they settle and well before the next edge. Expected values come from a separate behavioural model in the bench and from fixed literals for the stated compare and inversion examples. Neither source uses the design's shared-carry structure.

// File: rtl/risc_alu.sv
module risc_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         opnd_a,
  input  logic [DATA_W-1:0]         opnd_b,
  input  logic [$clog2(DATA_W)-1:0] shift_amt,
  input  logic [3:0]                op_sel,
  output logic [DATA_W-1:0]         result,
  output logic                      zero
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_NOR  = 4'd4;
  localparam logic [3:0] OP_SLL  = 4'd5;
  localparam logic [3:0] OP_SRL  = 4'd6;
  localparam logic [3:0] OP_SLT  = 4'd7;
  localparam logic [3:0] OP_SLTU = 4'd8;
  localparam logic [3:0] OP_LUI  = 4'd9;

  // one carry chain for add, subtract and both compares
  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_full;
  logic              lt_signed, lt_unsigned;

  assign do_sub      = (op_sel == OP_SUB) || (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign b_eff       = do_sub ? ~opnd_b : opnd_b;
  assign sum_full    = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
  assign lt_signed   = (opnd_a[MSB] != opnd_b[MSB]) ? opnd_a[MSB] : sum_full[MSB];
  assign lt_unsigned = ~sum_full[DATA_W];

  always_comb begin
    unique case (op_sel)
      OP_ADD, OP_SUB: result = sum_full[DATA_W-1:0];
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = opnd_a | opnd_b;
      OP_NOR:         result = ~(opnd_a | opnd_b);
      OP_SLL:         result = opnd_a << shift_amt;
      OP_SRL:         result = opnd_a >> shift_amt;
      OP_SLT:         result = {{(DATA_W-1){1'b0}}, lt_signed};
      OP_SLTU:        result = {{(DATA_W-1){1'b0}}, lt_unsigned};
      OP_LUI:         result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
      default:        result = '0;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, shift_amt, op_sel})) begin
      AST_SUB_INVERSE: assert (op_sel != OP_SUB || result + opnd_b == opnd_a) else $error("subtract not inverse of add"); // R2
      AST_EQUAL_ZERO: assert (!(op_sel == OP_SUB && opnd_a == opnd_b) || zero) else $error("equal operands not zero"); // R11
      AST_CMP_BOOL: assert (!(op_sel == OP_SLT || op_sel == OP_SLTU) || result[DATA_W-1:1] == '0) else $error("compare not boolean"); // R7
      AST_LUI_LOW: assert (op_sel != OP_LUI || result[HALF-1:0] == '0) else $error("upper immediate low half set"); // R9
      AST_UNUSED_OP: assert (op_sel <= OP_LUI || (result == '0 && zero)) else $error("unused code nonzero"); // R10
      AST_NOR_INV: assert (!(op_sel == OP_NOR && opnd_b == '0) || (result ^ opnd_a) == '1) else $error("nor not inverse"); // R4
    end
  end
endmodule

// File: tb/risc_alu_bench.sv
module risc_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [4:0]   sh;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         zf;
  int           n_checks = 0;
  int           n_errors = 0;
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  risc_alu u_risc_alu (
    .opnd_a(a), .opnd_b(b), .shift_amt(sh), .op_sel(op),
    .result(res), .zero(zf)
  );

  function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic [4:0] s);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return x << s;
      4'd6: return x >> s;
      4'd7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd8: return (x < y) ? 32'd1 : 32'd0;
      4'd9: return {y[15:0], 16'h0000};
      default: return '0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [4:0] s);
    @(posedge clk);
    #2;
    op = o; a = x; b = y; sh = s;
    #3;
  endtask

  task automatic expect_val(input string req, input logic [W-1:0] exp);
    n_checks++;
    if (res !== exp || zf !== (exp == '0)) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got %h zero=%b, expected %h zero=%b",
               req, op, a, b, sh, res, zf, exp, (exp == '0));
    end
  endtask

  task automatic run(input string req, input logic [3:0] o, input logic [W-1:0] x,
                     input logic [W-1:0] y, input logic [4:0] s);
    apply(o, x, y, s);
    expect_val(req, model(o, x, y, s));
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic t_idle;
    apply(4'd0, '0, '0, '0);
    expect_val("R11 idle", 32'h0);
  endtask

  task automatic t_add;
    apply(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0); expect_val("R1 wrap", 32'h0);
    apply(4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 0); expect_val("R1 ovf", 32'h8000_0000);
    run("R1", 4'd0, 32'h1234_5678, 32'h1111_1111, 0);
  endtask

  task automatic t_sub;
    apply(4'd1, 32'h0, 32'h1, 0); expect_val("R2 borrow", 32'hFFFF_FFFF);
    apply(4'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0); expect_val("R11 equal", 32'h0);
    apply(4'd1, 32'h8000_0000, 32'h1, 0); expect_val("R2 wrap", 32'h7FFF_FFFF);
  endtask

  task automatic t_logic;
    apply(4'd2, 32'h0000_3C00, 32'h0000_0DC0, 0); expect_val("R3 and", 32'h0000_0C00);
    apply(4'd3, 32'h0000_3C00, 32'h0000_0DC0, 0); expect_val("R3 or", 32'h0000_3DC0);
    apply(4'd4, 32'h0000_3C00, 32'h0, 0); expect_val("R4 inverse", 32'hFFFF_C3FF);
    run("R4", 4'd4, 32'hA5A5_0000, 32'h0F0F_0F0F, 0);
  endtask

  task automatic t_shift;
    apply(4'd5, 32'h8000_0001, 32'hFFFF_FFFF, 5'd31); expect_val("R5 max", 32'h8000_0000);
    apply(4'd5, 32'h0000_000B, 32'h1234_5678, 5'd4); expect_val("R5 fill", 32'h0000_00B0);
    apply(4'd5, 32'hCAFE_F00D, 32'h0, 5'd0); expect_val("R5 zero", 32'hCAFE_F00D);
    apply(4'd6, 32'h8000_0000, 32'hFFFF_FFFF, 5'd31); expect_val("R6 max", 32'h0000_0001);
    apply(4'd6, 32'hF000_0000, 32'h0, 5'd4); expect_val("R6 fill", 32'h0F00_0000);
  endtask

  task automatic t_compare;
    apply(4'd7, 32'hFFFF_FFFF, 32'h1, 0); expect_val("R7 neg", 32'h1);
    apply(4'd8, 32'hFFFF_FFFF, 32'h1, 0); expect_val("R8 big", 32'h0);
    apply(4'd7, 32'h7FFF_FFFF, 32'h8000_0000, 0); expect_val("R7 extremes", 32'h0);
    apply(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 0); expect_val("R8 extremes", 32'h1);
    apply(4'd7, 32'h5, 32'h5, 0); expect_val("R7 equal", 32'h0);
    apply(4'd8, 32'h4, 32'h5, 0); expect_val("R8 less", 32'h1);
  endtask

  task automatic t_lui;
    apply(4'd9, 32'hFFFF_FFFF, 32'h1234_003D, 0); expect_val("R9", 32'h003D_0000);
    apply(4'd9, 32'h0, 32'hFFFF_0000, 0); expect_val("R9 low", 32'h0);
  endtask

  task automatic t_unused;
    for (int c = 10; c < 16; c++) begin
      apply(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3);
      expect_val("R10", 32'h0);
    end
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      lfsr = step(lfsr); x = lfsr;
      lfsr = step(lfsr); y = (i % 7 == 0) ? x : lfsr;
      run("R1..R11 sweep", 4'(i % 16), x, y, 5'(lfsr[9:5]));
    end
  endtask

  initial begin
    a = '0; b = '0; sh = '0; op = '0;
    t_idle;
    t_add;
    t_sub;
    t_logic;
    t_shift;
    t_compare;
    t_lui;
    t_unused;
    t_sweep;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule